// File: doc/BRIEF.md
# Six-Pulse Thyristor Firing Sequencer

This block times the gate-trigger pulses of a three-phase bridge rectifier built from six thyristors. Its only timing source is a logic-level square wave that has already been brought into the clock domain and whose two edges mark the line zero crossings. The block counts clock cycles between rising edges to learn the line period. From that count it builds six firing slots spaced one sixth of a period apart. Every pulse is pushed later by a firing angle, which sets the DC level that the bridge delivers.

Slots 0 to 2 are timed from the most recent rising edge and slots 3 to 5 from the most recent falling edge. A small error in the duty cycle of the reference therefore moves only half of the pulses. The block runs open loop: pulse timing follows the reference edges as they arrive, with no correction for detector error. No data streams through the block, so it has no valid/ready handshake. The firing-angle word, the pulse width and the enable are plain control levels, and back-pressure does not apply.

Top module: `sixpulse_fire_seq`

## Requirements
- R1: While `rst_n` is low, all six `gate` bits are 0.
- R2: After reset, `gate` stays 0 until the second rising edge of `ref_in` has been sampled. Firing starts from that edge. A rising edge is a clock edge at which `ref_in` is 1 and was 0 at the previous clock edge.
- R3: At each rising edge, the period P is the number of clock edges since the previous rising edge. The slot step is S = floor(P/6).
- R4: Let E be the clock edge at which a rising edge is sampled. For k = 0, 1, 2, `gate[k]` goes to 1 at clock edge E + D + k*S + 1.
- R5: The delay is D = floor(A*P/512), where A is the 8-bit value of `fire_angle` sampled at the rising edge (0 maps to 0 and 256 would map to 180 degrees). Changes to `fire_angle` between rising edges have no effect until the next rising edge.
- R6: Each pulse lasts W = min(`pulse_width`, S) cycles, with `pulse_width` sampled at the rising edge. A width of 0 produces no pulse, and a pulse never outlasts its own slot.
- R7: For k = 3, 4, 5, `gate[k]` goes to 1 at clock edge F + D + (k-3)*S + 1, where F is a falling-edge clock edge (`ref_in` 0 after 1). D, S and W are the values latched at the preceding rising edge and are frozen at F. These outputs fire only after a falling edge seen once R2 is met.
- R8: When `enable` is sampled low at a clock edge, all `gate` bits are 0 after that edge. `enable` does not clear the measured period or the armed state.
- R9: Each gate asserts at most one contiguous pulse per interval between successive reference edges of its own polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Synchronized zero-crossing reference square wave |
| fire_angle | input | ANG_W (8) | Firing angle, 0 to 255 over 0 to 180 degrees |
| pulse_width | input | PW_W (16) | Gate pulse width in clock cycles |
| enable | input | 1 | Allows gate outputs when high |
| gate | output | 6 | Thyristor gate triggers, bit k fires at k*60 degrees plus the delay |

## Verification
The hardest case to reach is a falling-half pulse whose window still runs when the next edge arrives, or one that was latched under an older period and angle. It only happens when the period, the duty cycle and the angle all change between line cycles. The stimulus draws a new period, high time, angle and width at random for every short burst of reference cycles. It also changes the angle on random clock cycles in between edges, so that capture at the rising edge and freezing at the falling edge are both exercised under stale values. Directed bursts add angles 0 and 255, a zero width, an oversized width and a toggling enable.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int NGATE    = 6;
  localparam int HALF     = NGATE / 2;
  localparam int SLOT_DIV = 6;
endpackage

// File: rtl/sfs_period_meter.sv
module sfs_period_meter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] t_rise,
  output logic [CNT_W-1:0] t_fall,
  output logic [CNT_W-1:0] per_now,
  output logic             armed,
  output logic             half_ok
);
  localparam logic [CNT_W-1:0] TMAX = {{(CNT_W-1){1'b1}}, 1'b0};

  logic ref_d;
  logic seen1;

  assign rise    = ref_in & ~ref_d;
  assign fall    = ~ref_in & ref_d;
  assign per_now = t_rise + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      seen1   <= 1'b0;
      armed   <= 1'b0;
      half_ok <= 1'b0;
      t_rise  <= '0;
      t_fall  <= '0;
    end else begin
      ref_d <= ref_in;
      if (rise) begin
        t_rise <= '0;
        seen1  <= 1'b1;
        if (seen1) armed <= 1'b1;
      end else if (t_rise != TMAX) begin
        t_rise <= t_rise + 1'b1;
      end
      if (fall) begin
        t_fall <= '0;
        if (armed) half_ok <= 1'b1;
      end else if (t_fall != TMAX) begin
        t_fall <= t_fall + 1'b1;
      end
    end
  end

  // R3: the phase count restarts on each rising edge
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (t_rise == '0));
  // R2: arming happens only on a rising edge
  p_arm_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(rise));
  // R7: the falling half is never enabled ahead of arming
  p_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_ok |-> armed);
endmodule

// File: rtl/sfs_slot_calc.sv
module sfs_slot_calc #(
  parameter int CNT_W = 22,
  parameter int ANG_W = 8,
  parameter int PW_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise,
  input  logic                       fall,
  input  logic [CNT_W-1:0]           per_now,
  input  logic [ANG_W-1:0]           angle,
  input  logic [PW_W-1:0]            pw,
  output logic [sfs_pkg::HALF-1:0][CNT_W-1:0] r_off,
  output logic [sfs_pkg::HALF-1:0][CNT_W-1:0] f_off,
  output logic [CNT_W-1:0]           r_wid,
  output logic [CNT_W-1:0]           f_wid
);
  localparam int PROD_W = ANG_W + CNT_W;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  dly_now, stp_now, pw_x, wid_now;
  logic [CNT_W-1:0]  r_dly, r_stp, f_dly, f_stp;

  assign prod    = {{CNT_W{1'b0}}, angle} * {{ANG_W{1'b0}}, per_now};
  assign dly_now = CNT_W'(prod >> (ANG_W + 1));
  assign stp_now = per_now / CNT_W'(sfs_pkg::SLOT_DIV);
  assign pw_x    = {{(CNT_W-PW_W){1'b0}}, pw};
  assign wid_now = (pw_x > stp_now) ? stp_now : pw_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dly <= '0; r_stp <= '0; r_wid <= '0;
      f_dly <= '0; f_stp <= '0; f_wid <= '0;
    end else begin
      if (rise) begin
        r_dly <= dly_now;
        r_stp <= stp_now;
        r_wid <= wid_now;
      end
      if (fall) begin
        f_dly <= r_dly;
        f_stp <= r_stp;
        f_wid <= r_wid;
      end
    end
  end

  for (genvar k = 0; k < sfs_pkg::HALF; k++) begin : g_off
    assign r_off[k] = r_dly + CNT_W'(k) * r_stp;
    assign f_off[k] = f_dly + CNT_W'(k) * f_stp;
  end

  // R5: the delay moves only at a rising edge
  p_hold_angle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(r_dly));
  // R7: falling-half timing is frozen between falling edges
  p_hold_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(f_dly) && $stable(f_wid)));
endmodule

// File: rtl/sfs_gate_win.sv
module sfs_gate_win #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_ok,
  input  logic [CNT_W-1:0] t,
  input  logic [CNT_W-1:0] off,
  input  logic [CNT_W-1:0] wid,
  output logic             g
);
  logic hit;

  assign hit = (t >= off) && ((t - off) < wid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g <= 1'b0;
    else        g <= en_ok & hit;
  end

  // R6: a zero-width setting never yields a pulse
  p_zero_wid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wid == '0) |=> !g);
endmodule

// File: rtl/sixpulse_fire_seq.sv
module sixpulse_fire_seq #(
  parameter int CNT_W = 22,
  parameter int ANG_W = 8,
  parameter int PW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [ANG_W-1:0] fire_angle,
  input  logic [PW_W-1:0]  pulse_width,
  input  logic             enable,
  output logic [5:0]       gate
);
  import sfs_pkg::*;

  logic             rise, fall, armed, half_ok;
  logic [CNT_W-1:0] t_rise, t_fall, per_now, r_wid, f_wid;
  logic [HALF-1:0][CNT_W-1:0] r_off, f_off;

  sfs_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .rise(rise), .fall(fall), .t_rise(t_rise), .t_fall(t_fall),
    .per_now(per_now), .armed(armed), .half_ok(half_ok)
  );

  sfs_slot_calc #(.CNT_W(CNT_W), .ANG_W(ANG_W), .PW_W(PW_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .per_now(per_now), .angle(fire_angle), .pw(pulse_width),
    .r_off(r_off), .f_off(f_off), .r_wid(r_wid), .f_wid(f_wid)
  );

  for (genvar k = 0; k < NGATE; k++) begin : g_gate
    if (k < HALF) begin : g_rise_half
      sfs_gate_win #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .en_ok(enable & armed),
        .t(t_rise), .off(r_off[k]), .wid(r_wid), .g(gate[k])
      );
    end else begin : g_fall_half
      sfs_gate_win #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .en_ok(enable & half_ok),
        .t(t_fall), .off(f_off[k-HALF]), .wid(f_wid), .g(gate[k])
      );
    end
  end

  // R8: a low enable silences every output on the next cycle
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate == '0));
  // R2: nothing fires before arming
  p_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (gate == '0));
endmodule

// File: tb/sim_sixpulse_fire_seq.sv
`timescale 1ns/1ps
module sim_sixpulse_fire_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [7:0] fire_angle = '0;
  logic [15:0] pulse_width = '0;
  logic       enable = 1'b1;
  logic [5:0] gate;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";

  sixpulse_fire_seq u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fire_angle(fire_angle),
    .pulse_width(pulse_width), .enable(enable), .gate(gate)
  );

  always #2.5 clk = ~clk;

  // reference model built from the requirement formulas
  int cyc, lr, lf, rd, rs, rw, fd, fs, fw;
  bit mprev, mseen, marm, mhalf;
  logic [5:0] expg;

  function automatic bit in_win(int t, int off, int w);
    return (t >= off) && (t - off < w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; lr = 0; lf = 0; rd = 0; rs = 0; rw = 0; fd = 0; fs = 0; fw = 0;
      mprev = 0; mseen = 0; marm = 0; mhalf = 0; expg = '0;
    end else begin
      cyc++;
      for (int k = 0; k < 3; k++) begin
        expg[k]   = marm && enable && in_win(cyc - 1 - lr, rd + k * rs, rw);
        expg[k+3] = mhalf && enable && in_win(cyc - 1 - lf, fd + k * fs, fw);
      end
      if (ref_in && !mprev) begin
        if (mseen) begin
          int p;
          p = cyc - lr;
          rd = (int'(fire_angle) * p) / 512;
          rs = p / 6;
          rw = (int'(pulse_width) < rs) ? int'(pulse_width) : rs;
          marm = 1;
        end
        mseen = 1;
        lr = cyc;
      end
      if (!ref_in && mprev) begin
        if (marm) begin
          fd = rd; fs = rs; fw = rw; mhalf = 1;
        end
        lf = cyc;
      end
      mprev = ref_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (gate !== expg) begin
        errors++;
        $display("FAIL %s gate=%b expected=%b cycle=%0d", tag, gate, expg, cyc);
      end
    end
  end

  bit jitter = 0;

  task automatic run_cycles(int p, int h, int n);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < p; i++) begin
        @(negedge clk);
        ref_in = (i < h);
        if (jitter && ($urandom % 7 == 0)) fire_angle = 8'($urandom);
      end
    end
  endtask

  task automatic rand_burst(int n);
    int p, h;
    p = 60 + int'($urandom % 240);
    h = p / 3 + int'($urandom % (p / 3));
    fire_angle  = 8'($urandom);
    pulse_width = 16'(1 + $urandom % (p / 5));
    run_cycles(p, h, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++; // R1: outputs low in reset
    if (gate !== 6'b0) begin
      errors++;
      $display("FAIL R1 gate=%b expected=000000", gate);
    end
    rst_n = 1'b1;

    tag = "R2 R4";
    fire_angle = 8'd64; pulse_width = 16'd5;
    run_cycles(120, 60, 3);

    tag = "R3 R4 R7 R9";
    for (int b = 0; b < 14; b++) rand_burst(3);

    tag = "R5";
    jitter = 1;
    for (int b = 0; b < 4; b++) rand_burst(4);
    jitter = 0;

    tag = "R6";
    pulse_width = 16'd0;      run_cycles(150, 75, 2);
    pulse_width = 16'hFFFF;   run_cycles(150, 75, 2);
    pulse_width = 16'd1;      run_cycles(90, 40, 2);

    tag = "R4 R5 boundary";
    pulse_width = 16'd7;
    fire_angle = 8'd0;        run_cycles(132, 66, 2);
    fire_angle = 8'd255;      run_cycles(132, 66, 2);

    tag = "R8";
    fork
      run_cycles(200, 100, 4);
      begin
        for (int i = 0; i < 800; i++) begin
          @(negedge clk);
          if ($urandom % 23 == 0) enable = ~enable;
        end
      end
    join
    enable = 1'b0; run_cycles(200, 100, 2);
    enable = 1'b1; run_cycles(200, 100, 2);

    tag = "R3 R7 R9";
    for (int b = 0; b < 6; b++) rand_burst(2);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule